// File: doc/BRIEF.md
# MSI Doorbell Capture and Aggregation

This block is the landing zone for message-signalled interrupt writes coming out of a PCIe root port. Each doorbell is a plain memory-mapped write. The write address picks one of 128 pending registers, each 32 bits wide. The low five bits of the write data pick the bit to set. The registers are arranged as 16 groups of 8. That gives 4096 vectors in all.

Each group drives one active-high, level-sensitive interrupt line. The line stays high while any bit in the group is pending.

Software services a group in two steps:
1. It reads the group's summary word to find which of the 8 registers hold work.
2. It reads those registers. A read of a pending register returns its bits and clears them in the same access, so no acknowledge write is needed.

Both ports use a valid/ready handshake. Ready is always high, so every request is taken in the cycle it is presented.

Top module: `msi_doorbell_agg`

## Requirements
- R1: Vector v lives in group v mod 16, register v / 512 (integer division), and bit (v / 16) mod 32.
- R2: A write whose address has bit 23 clear and bits [15:0] zero is a doorbell. It sets bit wr_data[4:0] of register address[18:16] in group address[22:19]. The bit is readable from the next cycle on. wr_data[31:5] are ignored.
- R3: A read accepted at a clock edge produces rd_rsp_valid high for exactly the following cycle. The result is on rd_rsp_data. An index read uses the same address layout as a doorbell.
- R4: An index read returns the register's pending bits and leaves that register all-zero afterwards.
- R5: A read at 0x800000 + (g << 16) returns the summary of group g. Bit n is set when register n of the group is nonzero. Bits [31:8] read zero. The read does not clear anything.
- R6: irq[g] is high exactly while group g holds any pending bit. It falls in the cycle after the last bit is read out, and it rises again on the next doorbell to that group.
- R7: When a doorbell and an index read hit the same register at the same edge, the read returns the old contents and the doorbell's bit stays pending.
- R8: A doorbell for a bit that is already pending leaves the register unchanged. One read clears it.
- R9: Writes with bit 23 set, or with nonzero bits [15:0], change no pending state and no irq line. Reads of addresses that are neither index nor summary locations return zero.
- R10: After reset every register, summary bit, irq line and rd_rsp_valid is low.
- R11: wr_ready and rd_ready are high whenever reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Doorbell write request |
| wr_ready | output | 1 | Write accepted (always high) |
| wr_addr | input | 24 | Write byte offset from block base |
| wr_data | input | 32 | Write data; bits [4:0] pick the bit |
| rd_valid | input | 1 | Read request |
| rd_ready | output | 1 | Read accepted (always high) |
| rd_addr | input | 24 | Read byte offset from block base |
| rd_rsp_valid | output | 1 | Read data valid, one cycle after acceptance |
| rd_rsp_data | output | 32 | Read data |
| irq | output | 16 | One level interrupt per group |

## Verification
The bench targets the following corner cases, each paired with the faulty behaviour it would expose:
- A doorbell and a read-clear to the same register in one cycle. A design that lets the clear win loses the new vector. A design that returns the new bit counts it twice.
- The extreme vector 4095 and vectors that share a group but differ in register. Swapped group and register fields, or a wrong data-to-bit mapping, put these bits in the wrong word.
- Writes into the summary window and writes with stray low address bits. A loose decoder would set phantom bits or raise irq.
- A summary read followed by a second summary read. A design that clears on summary reads would report an empty group the second time.

// File: rtl/msi_agg_pkg.sv
`timescale 1ns/1ps
package msi_agg_pkg;
    // Kind of location an address decodes to.
    typedef enum logic [1:0] {
        ACC_NONE    = 2'd0,
        ACC_INDEX   = 2'd1,
        ACC_SUMMARY = 2'd2
    } acc_kind_e;
endpackage

// File: rtl/msi_addr_decode.sv
`timescale 1ns/1ps
module msi_addr_decode
    import msi_agg_pkg::*;
#(
    parameter int GRP_W      = 4,
    parameter int REG_W      = 3,
    parameter int SLOT_SHIFT = 16,
    localparam int HI        = SLOT_SHIFT + REG_W + GRP_W,
    localparam int ADDR_W    = HI + 1
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind,
    output logic [GRP_W-1:0]  grp,
    output logic [REG_W-1:0]  idx
);
    logic low_clear;
    logic sum_pad_clear;

    // Every mapped location sits on a slot boundary.
    assign low_clear     = (addr[SLOT_SHIFT-1:0] == '0);
    // Summary slots use only the group field above the slot bits.
    assign sum_pad_clear = (addr[HI-1:SLOT_SHIFT+GRP_W] == '0);

    always_comb begin
        kind = ACC_NONE;
        grp  = '0;
        idx  = '0;
        if (low_clear && !addr[HI]) begin
            kind = ACC_INDEX;
            grp  = addr[SLOT_SHIFT+REG_W +: GRP_W];
            idx  = addr[SLOT_SHIFT +: REG_W];
        end else if (low_clear && addr[HI] && sum_pad_clear) begin
            kind = ACC_SUMMARY;
            grp  = addr[SLOT_SHIFT +: GRP_W];
        end
    end
endmodule

// File: rtl/msi_group_bank.sv
`timescale 1ns/1ps
module msi_group_bank #(
    parameter int N_IDX    = 8,
    parameter int VEC_W    = 32,
    localparam int REG_W   = $clog2(N_IDX),
    localparam int BIT_W   = $clog2(VEC_W)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        set_en,
    input  logic [REG_W-1:0]            set_idx,
    input  logic [BIT_W-1:0]            set_bit,
    input  logic                        clr_en,
    input  logic [REG_W-1:0]            clr_idx,
    output logic [N_IDX-1:0][VEC_W-1:0] pend_o,
    output logic [N_IDX-1:0]            summary_o,
    output logic                        irq_o
);
    typedef struct packed {
        logic [N_IDX-1:0][VEC_W-1:0] pend;
    } bank_st_t;

    bank_st_t st_d, st_q;

    // Clear first, then set: a doorbell landing with a read-clear survives.
    always_comb begin
        st_d = st_q;
        if (clr_en) begin
            st_d.pend[clr_idx] = '0;
        end
        if (set_en) begin
            st_d.pend[set_idx][set_bit] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar i = 0; i < N_IDX; i++) begin : g_sum
        assign summary_o[i] = |st_q.pend[i];
    end

    assign pend_o = st_q.pend;
    assign irq_o  = |summary_o;

    AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> st_q.pend[$past(set_idx)][$past(set_bit)]); // R2
    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !(set_en && set_idx == clr_idx)) |=> (st_q.pend[$past(clr_idx)] == '0)); // R4
    AST_COLLIDE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && set_en && set_idx == clr_idx) |=> ($countones(st_q.pend[$past(clr_idx)]) == 1)); // R7
    AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(set_en)); // R6
endmodule

// File: rtl/msi_doorbell_agg.sv
`timescale 1ns/1ps
module msi_doorbell_agg
    import msi_agg_pkg::*;
#(
    parameter int N_GROUPS   = 16,
    parameter int N_IDX      = 8,
    parameter int VEC_W      = 32,
    parameter int SLOT_SHIFT = 16,
    localparam int GRP_W     = $clog2(N_GROUPS),
    localparam int REG_W     = $clog2(N_IDX),
    localparam int BIT_W     = $clog2(VEC_W),
    localparam int ADDR_W    = SLOT_SHIFT + REG_W + GRP_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_valid,
    output logic                wr_ready,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [VEC_W-1:0]    wr_data,
    input  logic                rd_valid,
    output logic                rd_ready,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic                rd_rsp_valid,
    output logic [VEC_W-1:0]    rd_rsp_data,
    output logic [N_GROUPS-1:0] irq
);
    typedef struct packed {
        logic             vld;
        logic [VEC_W-1:0] data;
    } rsp_st_t;

    acc_kind_e        wr_kind, rd_kind;
    logic [GRP_W-1:0] wr_grp, rd_grp;
    logic [REG_W-1:0] wr_idx, rd_idx;
    logic             wr_fire, rd_fire;
    logic             unused_wr_hi;

    logic [N_GROUPS-1:0][N_IDX-1:0][VEC_W-1:0] pend_all;
    logic [N_GROUPS-1:0][N_IDX-1:0]            summ_all;

    rsp_st_t rsp_d, rsp_q;

    assign wr_ready = rst_n;
    assign rd_ready = rst_n;
    assign wr_fire  = wr_valid && wr_ready;
    assign rd_fire  = rd_valid && rd_ready;
    assign unused_wr_hi = ^wr_data[VEC_W-1:BIT_W];

    msi_addr_decode #(.GRP_W(GRP_W), .REG_W(REG_W), .SLOT_SHIFT(SLOT_SHIFT)) u_wr_dec (
        .addr (wr_addr),
        .kind (wr_kind),
        .grp  (wr_grp),
        .idx  (wr_idx)
    );

    msi_addr_decode #(.GRP_W(GRP_W), .REG_W(REG_W), .SLOT_SHIFT(SLOT_SHIFT)) u_rd_dec (
        .addr (rd_addr),
        .kind (rd_kind),
        .grp  (rd_grp),
        .idx  (rd_idx)
    );

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_bank
        logic set_en_g, clr_en_g;
        assign set_en_g = wr_fire && (wr_kind == ACC_INDEX) && (wr_grp == GRP_W'(g));
        assign clr_en_g = rd_fire && (rd_kind == ACC_INDEX) && (rd_grp == GRP_W'(g));

        msi_group_bank #(.N_IDX(N_IDX), .VEC_W(VEC_W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_en    (set_en_g),
            .set_idx   (wr_idx),
            .set_bit   (wr_data[BIT_W-1:0]),
            .clr_en    (clr_en_g),
            .clr_idx   (rd_idx),
            .pend_o    (pend_all[g]),
            .summary_o (summ_all[g]),
            .irq_o     (irq[g])
        );
    end

    // Read data is sampled from the state before this edge's clear.
    always_comb begin
        rsp_d      = '0;
        rsp_d.vld  = rd_fire;
        if (rd_fire) begin
            unique case (rd_kind)
                ACC_INDEX:   rsp_d.data = pend_all[rd_grp][rd_idx];
                ACC_SUMMARY: rsp_d.data = VEC_W'(summ_all[rd_grp]);
                default:     rsp_d.data = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rd_rsp_valid = rsp_q.vld;
    assign rd_rsp_data  = rsp_q.data;

    AST_RSP_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire |=> rd_rsp_valid); // R3
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_fire |=> !rd_rsp_valid); // R3
    AST_STRAY_WR_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && wr_kind != ACC_INDEX) |=> ((irq & ~$past(irq)) == '0)); // R9
    AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready && rd_ready); // R11
endmodule

// File: tb/sim_msi_doorbell_agg.sv
`timescale 1ns/1ps
module sim_msi_doorbell_agg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [23:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_valid = 1'b0;
    logic        rd_ready;
    logic [23:0] rd_addr = '0;
    logic        rd_rsp_valid;
    logic [31:0] rd_rsp_data;
    logic [15:0] irq;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] mdl [16][8];
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    msi_doorbell_agg u0 (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // R1 vector placement
    function automatic logic [23:0] vec_addr(input int v);
        return 24'(((v % 16) << 19) | ((v / 512) << 16));
    endfunction
    function automatic logic [31:0] vec_data(input int v);
        return 32'((v / 16) % 32);
    endfunction
    function automatic logic [23:0] sum_addr(input int g);
        return 24'(32'h800000 + (g << 16));
    endfunction

    function automatic bit is_idx(input logic [23:0] a);
        return !a[23] && a[15:0] == 16'h0;
    endfunction
    function automatic bit is_sum(input logic [23:0] a);
        return a[23] && a[22:20] == 3'h0 && a[15:0] == 16'h0;
    endfunction

    function automatic logic [31:0] model_read(input logic [23:0] a);
        logic [31:0] r;
        r = '0;
        if (is_idx(a)) begin
            r = mdl[a[22:19]][a[18:16]];
        end else if (is_sum(a)) begin
            for (int i = 0; i < 8; i++) r[i] = |mdl[a[19:16]][i];
        end
        return r;
    endfunction

    // One bus cycle; starts and ends at a falling edge.
    task automatic step(input logic wv, input logic [23:0] wa, input logic [31:0] wd,
                        input logic rv, input logic [23:0] ra, input string tag);
        wr_valid = wv; wr_addr = wa; wr_data = wd;
        rd_valid = rv; rd_addr = ra;
        if (rv) begin
            exp_q.push_back(model_read(ra));
            tag_q.push_back(tag);
        end
        @(posedge clk);
        if (rv && is_idx(ra)) mdl[ra[22:19]][ra[18:16]] = '0;
        if (wv && is_idx(wa)) mdl[wa[22:19]][wa[18:16]][wd[4:0]] = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
        rd_valid = 1'b0;
    endtask

    task automatic ring(input int v);
        step(1'b1, vec_addr(v), vec_data(v), 1'b0, '0, "R2");
    endtask

    task automatic rd(input logic [23:0] a, input string tag);
        step(1'b0, '0, '0, 1'b1, a, tag);
    endtask

    task automatic check_irq(input string tag);
        logic [15:0] e;
        for (int g = 0; g < 16; g++) begin
            e[g] = 1'b0;
            for (int i = 0; i < 8; i++) e[g] = e[g] | (|mdl[g][i]);
        end
        chk(tag, 32'(irq), 32'(e));
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rd_rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk("R3 unexpected response", 32'(rd_rsp_valid), 32'h0);
            end else begin
                chk(tag_q.pop_front(), rd_rsp_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int g = 0; g < 16; g++)
            for (int i = 0; i < 8; i++) mdl[g][i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state, R11 readiness
        chk("R10 irq after reset", 32'(irq), 32'h0);
        chk("R10 rsp_valid after reset", 32'(rd_rsp_valid), 32'h0);
        chk("R11 ready", 32'({wr_ready, rd_ready}), 32'h3);
        rd(sum_addr(0), "R10 summary g0");
        rd(sum_addr(15), "R10 summary g15");

        // R1 R2 placement of several vectors
        ring(0); ring(17); ring(4095); ring(513); ring(34);
        check_irq("R6 irq after doorbells");
        rd(sum_addr(1), "R5 summary g1 two regs");
        rd(sum_addr(1), "R5 summary read does not clear");
        rd(sum_addr(15), "R5 summary g15 reg7");
        rd(vec_addr(4095), "R1 vector 4095 at g15 r7 b31");
        check_irq("R6 irq g15 falls after read");
        rd(vec_addr(17), "R1 vector 17 at g1 r0 b1");
        rd(vec_addr(17), "R4 reread returns zero");
        check_irq("R6 irq g1 still high from r1");
        rd(vec_addr(513), "R1 vector 513 at g1 r1 b0");
        check_irq("R6 irq g1 low");
        ring(513);
        check_irq("R6 irq g1 reasserts");

        // R8 duplicate merges
        ring(34); ring(34);
        rd(vec_addr(34), "R8 duplicate merged");
        rd(vec_addr(34), "R8 single read clears");

        // R2 upper data bits ignored
        step(1'b1, 24'h180000, 32'hFFFF_FFE3, 1'b0, '0, "R2");
        rd(24'h180000, "R2 only data[4:0] used");

        // R7 collision: g0 r0 holds bit 0; write bit 5 while reading
        step(1'b1, 24'h000000, 32'd5, 1'b1, 24'h000000, "R7 read sees old value");
        rd(24'h000000, "R7 new bit survives");
        check_irq("R7 irq g0 low after drain");

        // R9 ignored writes and unmapped reads
        step(1'b1, sum_addr(3), 32'd4, 1'b0, '0, "R9");
        step(1'b1, 24'h180004, 32'd4, 1'b0, '0, "R9");
        step(1'b1, 24'h900000, 32'd4, 1'b0, '0, "R9");
        check_irq("R9 irq unchanged by stray writes");
        rd(24'h180000, "R9 index untouched by stray writes");
        rd(sum_addr(3), "R9 summary g3 untouched");
        ring(2);
        rd(24'h000010, "R9 unmapped read zero");
        rd(24'h900000, "R9 unmapped summary-pad read zero");
        rd(vec_addr(2), "R9 unmapped reads cleared nothing");
        rd(vec_addr(513), "R4 drain g1");
        check_irq("R6 all low at end");

        @(negedge clk);
        chk("R3 all responses seen", 32'(exp_q.size()), 32'h0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule